// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs a single conversion on an external 12-bit serial analog-to-digital converter. It drives four pins: an active-low select, a serial clock, a line toward the converter, and a line from it. A one-cycle start request captures a control byte that holds the channel, gain and polarity settings. The block turns that byte into a command word and sends it. It then gives the converter the extra clock pulses it needs to finish acquiring the sample, and shifts the 12-bit result back in. The result appears as a low byte and a high byte, and a one-cycle done strobe marks it as valid.

The serial clock comes from the system clock through a divider set by the parameter `SCLK_HALF`. Each high phase and each low phase of the serial clock lasts `SCLK_HALF` system cycles. A conversion takes 25 serial clock pulses in a fixed sequence. A state machine controls the sequence, and the states run in this order:

- `ST_IDLE`: select released and clock parked low. Moves to `ST_CMD` on start.
- `ST_CMD`: 8 command bits. Moves to `ST_ACQ` after the 8th pulse.
- `ST_ACQ`: 5 acquisition pulses. Moves to `ST_RDHI` after the 5th.
- `ST_RDHI`: 4 high result bits. Moves to `ST_RDLO` after the 4th.
- `ST_RDLO`: 8 low result bits. Moves to `ST_FINISH` after the 8th.
- `ST_FINISH`: select released and done strobe asserted for one cycle. Always returns to `ST_IDLE`.

Each transition out of a shifting state happens on the falling edge of the serial clock that ends the last pulse of that state.

Top module: `adc_conv_seq`

## Requirements
- R1: Out of reset, and whenever idle, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_sdo` is 0, and `busy` and `done` are 0. The serial clock is never high while `adc_cs_n` is 1.
- R2: The command word sent is `(ctrl_byte & 8'h7C) | 8'h81`, using the control byte captured with start. Bit 7 is the start bit (1), bits 6..2 come from the control byte, bit 1 is 0, and bit 0 selects external-clock mode (1).
- R3: `adc_cs_n` falls before the first serial clock rise. The command bits leave MSB first, and each bit is stable on `adc_sdo` throughout its high phase.
- R4: After the 8 command pulses, 5 further pulses follow with `adc_sdo` held at 0.
- R5: The next 4 bits, taken MSB first, form `res_hi[3:0]`. `res_hi[7:4]` is always 0.
- R6: The final 8 bits, taken MSB first, form `res_lo`.
- R7: `adc_sdi` is sampled during the high phase of the serial clock. Data that changes only after each falling edge is captured as the 12-bit value `{res_hi[3:0], res_lo}`.
- R8: Each high and each low phase of `adc_sclk` lasts `SCLK_HALF` system cycles. A conversion has exactly 25 pulses.
- R9: After the last pulse, `adc_cs_n` returns to 1 in the same cycle that `done` is 1. `done` lasts one cycle, and the result ports hold the new value while it is high.
- R10: A start request, or a change in `ctrl_byte`, while `busy` is 1 has no effect on the frame being sent or its result, and does not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion (accepted only when idle) |
| ctrl_byte | input | 8 | Channel, gain and polarity settings |
| busy | output | 1 | High from acceptance of start through the done cycle |
| done | output | 1 | One-cycle strobe: result bytes valid |
| res_lo | output | 8 | Low 8 bits of the result |
| res_hi | output | 8 | Upper 4 bits of the result in bits 3..0 |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_sdo | output | 1 | Serial data to converter |
| adc_sdi | input | 1 | Serial data from converter |

## Verification
The assertions assume that `adc_sdi` changes only while the serial clock is low, so that a sample taken at the end of a high phase sees a settled level. The bench's converter model follows this: it updates `adc_sdi` only on the half cycle after it sees a falling edge. The control-word and start-filter properties assume that `start` and `ctrl_byte` are synchronous to `clk`. The bench drives them only on falling edges of `clk`, including the start pulses it deliberately issues during a busy frame and in the done cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CMD_BITS  = 8;
    localparam int ACQ_CLKS  = 5;
    localparam int HI_BITS   = 4;
    localparam int LO_BITS   = 8;
    localparam int RES_BITS  = HI_BITS + LO_BITS;
    localparam int MAX_SEG   = 8;
    localparam int CNT_W     = $clog2(MAX_SEG + 1);

    localparam logic [7:0] CMD_KEEP  = 8'h7C;
    localparam logic [7:0] CMD_FORCE = 8'h81;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ACQ,
        ST_RDHI,
        ST_RDLO,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

    logic [CW-1:0] ph_cnt;
    logic          ph_end;

    assign ph_end    = (ph_cnt == LAST);
    assign rise_tick = en & ph_end & ~sclk;
    assign fall_tick = en & ph_end & sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (!en) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (ph_end) begin
            ph_cnt <= '0;
            sclk   <= ~sclk;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    // R8: a disabled generator parks the clock low on the next edge
    a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sclk);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] ctrl_byte,
    input  logic       sdi,
    input  logic       fall_tick,
    output logic       clk_en,
    output logic       cs_n,
    output logic       sdo,
    output logic       busy,
    output logic       done,
    output logic [7:0] res_lo,
    output logic [7:0] res_hi
);

    seq_state_t state, nxt;

    logic [CNT_W-1:0]   bit_cnt;
    logic [7:0]         cmd_sr;
    logic [HI_BITS-1:0] hi_sr;
    logic [LO_BITS-1:0] lo_sr;
    logic               seg_last;

    // last pulse of the current segment
    always_comb begin
        unique case (state)
            ST_CMD:  seg_last = (bit_cnt == CNT_W'(CMD_BITS - 1));
            ST_ACQ:  seg_last = (bit_cnt == CNT_W'(ACQ_CLKS - 1));
            ST_RDHI: seg_last = (bit_cnt == CNT_W'(HI_BITS - 1));
            ST_RDLO: seg_last = (bit_cnt == CNT_W'(LO_BITS - 1));
            default: seg_last = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)                nxt = ST_CMD;
            ST_CMD:    if (fall_tick && seg_last) nxt = ST_ACQ;
            ST_ACQ:    if (fall_tick && seg_last) nxt = ST_RDHI;
            ST_RDHI:   if (fall_tick && seg_last) nxt = ST_RDLO;
            ST_RDLO:   if (fall_tick && seg_last) nxt = ST_FINISH;
            ST_FINISH:                          nxt = ST_IDLE;
            default:                            nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // pulse counter within a segment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             bit_cnt <= '0;
        else if (state != nxt)  bit_cnt <= '0;
        else if (fall_tick)     bit_cnt <= bit_cnt + 1'b1;
    end

    // datapath: command shifter and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sr <= '0;
            hi_sr  <= '0;
            lo_sr  <= '0;
            res_lo <= '0;
            res_hi <= '0;
        end else begin
            if (state == ST_IDLE && start)
                cmd_sr <= (ctrl_byte & CMD_KEEP) | CMD_FORCE;
            else if (state == ST_CMD && fall_tick)
                cmd_sr <= {cmd_sr[6:0], 1'b0};

            if (state == ST_RDHI && fall_tick)
                hi_sr <= {hi_sr[HI_BITS-2:0], sdi};

            if (state == ST_RDLO && fall_tick) begin
                lo_sr <= {lo_sr[LO_BITS-2:0], sdi};
                if (seg_last) begin
                    res_lo <= {lo_sr[LO_BITS-2:0], sdi};
                    res_hi <= {{(8-HI_BITS){1'b0}}, hi_sr};
                end
            end
        end
    end

    // outputs
    always_comb begin
        clk_en = 1'b0;
        cs_n   = 1'b1;
        sdo    = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_CMD:    begin clk_en = 1'b1; cs_n = 1'b0; sdo = cmd_sr[7]; end
            ST_ACQ,
            ST_RDHI,
            ST_RDLO:   begin clk_en = 1'b1; cs_n = 1'b0; end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // R10: a frame is entered only from idle, never restarted mid-frame
    a_r10_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_CMD || $past(state) == ST_CMD));

    // R9: the finish state lasts exactly one cycle
    a_r9_finish_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |=> (state == ST_IDLE));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] ctrl_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] res_lo,
    output logic [7:0] res_hi,
    output logic       adc_cs_n,
    output logic       adc_sclk,
    output logic       adc_sdo,
    input  logic       adc_sdi
);

    logic clk_en;
    logic rise_tick;
    logic fall_tick;

    adc_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .sclk      (adc_sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    adc_frame_ctrl u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ctrl_byte (ctrl_byte),
        .sdi       (adc_sdi),
        .fall_tick (fall_tick),
        .clk_en    (clk_en),
        .cs_n      (adc_cs_n),
        .sdo       (adc_sdo),
        .busy      (busy),
        .done      (done),
        .res_lo    (res_lo),
        .res_hi    (res_hi)
    );

    // R1: serial clock never high with the converter deselected
    a_r1_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    // R3: data toward the converter is steady across a high phase
    a_r3_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk && $past(adc_sclk)) |-> $stable(adc_sdo));

    // R9: done is a single-cycle strobe with the select released
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_cs: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (adc_cs_n && busy));

    // R8: the rise tick of the divider only fires while selected
    a_r8_rise_sel: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> !adc_cs_n);

endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] ctrl_byte = 8'h00;
    logic       busy, done;
    logic [7:0] res_lo, res_hi;
    logic       adc_cs_n, adc_sclk, adc_sdo;
    logic       adc_sdi = 1'b0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_seq #(.SCLK_HALF(HALF)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ctrl_byte (ctrl_byte),
        .busy      (busy),
        .done      (done),
        .res_lo    (res_lo),
        .res_hi    (res_hi),
        .adc_cs_n  (adc_cs_n),
        .adc_sclk  (adc_sclk),
        .adc_sdo   (adc_sdo),
        .adc_sdi   (adc_sdi)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 cs_n idle", 32'(adc_cs_n), 1);
        chk(adc_sclk == 1'b0, "R1 sclk idle", 32'(adc_sclk), 0);
        chk(adc_sdo == 1'b0, "R1 sdo idle", 32'(adc_sdo), 0);
        chk({busy, done} == 2'b00, "R1 busy/done idle", 32'({busy, done}), 0);
    endtask

    // one conversion with a converter model sampled on falling clk edges
    task automatic t_conv(input logic [7:0] ctrl, input logic [11:0] val,
                          input bit poke);
        int rises = 0;
        int run = 0;
        int cyc = 0;
        bit phase_bad = 0;
        bit acq_bad = 0;
        bit cs_bad = 0;
        bit got = 0;
        logic prev = 1'b0;
        logic [7:0] cmd = 8'h00;
        logic [7:0] exp_cmd;
        logic [7:0] lo_q, hi_q;
        exp_cmd = (ctrl & 8'h7C) | 8'h81;
        @(negedge clk);
        ctrl_byte = ctrl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ctrl_byte = ~ctrl;
        prev = adc_sclk;
        while (!got && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = (poke && rises == 10) ? 1'b1 : 1'b0;
            if (adc_sclk && !prev) begin
                if (rises > 0 && run != HALF) phase_bad = 1;
                rises++;
                run = 1;
                if (adc_cs_n) cs_bad = 1;
                if (rises <= 8) cmd = {cmd[6:0], adc_sdo};
                else if (rises <= 13 && adc_sdo) acq_bad = 1;
            end else if (!adc_sclk && prev) begin
                if (run != HALF) phase_bad = 1;
                run = 1;
                if (rises + 1 >= 14 && rises + 1 <= 25) adc_sdi = val[24 - rises];
                else adc_sdi = 1'b0;
            end else begin
                run++;
            end
            prev = adc_sclk;
            if (done) begin
                got = 1;
                lo_q = res_lo;
                hi_q = res_hi;
                chk(adc_cs_n == 1'b1, "R9 cs_n high with done", 32'(adc_cs_n), 1);
                if (poke) start = 1'b1;
            end
        end
        adc_sdi = 1'b0;
        chk(got, "R9 done seen", 32'(got), 1);
        chk(cmd == exp_cmd, "R2 command word", 32'(cmd), 32'(exp_cmd));
        chk(!cs_bad, "R3 cs_n low at every rise", 32'(cs_bad), 0);
        chk(!acq_bad, "R4 sdo low in acquisition", 32'(acq_bad), 0);
        chk(rises == 25, "R8 pulse count", 32'(rises), 25);
        chk(!phase_bad, "R8 phase length", 32'(phase_bad), 0);
        chk(hi_q == {4'h0, val[11:8]}, "R5 high byte", 32'(hi_q), 32'({4'h0, val[11:8]}));
        chk(lo_q == val[7:0], "R6 low byte", 32'(lo_q), 32'(val[7:0]));
        chk({hi_q[3:0], lo_q} == val, "R7 sampled value", 32'({hi_q[3:0], lo_q}), 32'(val));
        @(negedge clk);
        start = 1'b0;
        chk(!done && !busy && adc_cs_n, "R9 single done, idle after",
            32'({done, busy, adc_cs_n}), 1);
        if (poke) begin
            @(negedge clk);
            chk(!busy && adc_cs_n, "R10 start while busy ignored",
                32'({busy, adc_cs_n}), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_conv(8'hFF, 12'hFFF, 1'b0);
        t_conv(8'h00, 12'h000, 1'b0);
        t_conv(8'hA5, 12'hA5C, 1'b0);
        t_conv(8'h5A, 12'h3C3, 1'b1);
        t_conv(8'h7E, 12'h801, 1'b1);
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule